// File: doc/BRIEF.md
# Software-Driven I2C Line Decoder

This block sits behind a general-purpose output register whose two bits drive an I2C data line and clock line under software control. Each time software writes the register, the block samples the two written line values and compares them with the values from the previous write. From those comparisons it rebuilds I2C framing: START and STOP conditions, the address byte with its read/write flag, written data bytes, and the bytes read back from a target.

On its byte-level side it produces single-cycle strobes: open a transfer with a 7-bit address and a direction flag, send a byte, request a byte, and close the transfer. A requested byte comes back later on a valid/data response input. When software reads the data line back, the block returns the level the target would drive. That level is 0 during the acknowledge slot after a byte is written. While a byte is being read it is the current data bit, most significant bit first. At all other times it is 1, the released line.

Top module: `i2c_gpio_framer`

## Requirements
- R1: After reset the readback level is 1, no strobe is active, and the previous line values are taken as SDA=1, SCL=1.
- R2: Framing begins only from idle on a START, which is a write where SDA goes from 1 to 0 while SCL is 1. Clock activity before a START produces no strobe.
- R3: After a START, the next falling SCL write with SDA 0 opens the first bit slot. Eight falling SCL writes then capture the written SDA values MSB first. The ninth falling edge (the acknowledge clock) of the first byte raises the start strobe, with the address equal to byte bits 7..1 and the read flag equal to byte bit 0.
- R4: Between the eighth falling edge of a written byte and the acknowledge falling edge, the readback level is 0.
- R5: When the read flag is 0, each further byte raises the send strobe with that byte on its acknowledge falling edge. No send strobe ever occurs while the held read flag is 1.
- R6: When the read flag is 1, the acknowledge falling edge of the address byte raises the receive request. The byte returned on the response is shown on the readback, MSB first. Each falling SCL write advances one bit.
- R7: After eight received bits the readback is 1 (master acknowledge slot). The next falling SCL write raises a new receive request and restarts at the first bit.
- R8: In any state other than idle, a write where SDA goes from 0 to 1 while SCL is 1 is a STOP. It returns to idle with readback 1 and raises the end strobe only if an address is held. A STOP before any address was completed raises no end strobe.
- R9: Every strobe is high for exactly the one cycle after the clock edge that sampled the causing write.
- R10: A response that arrives when no receive request is outstanding is ignored, and the readback is unchanged.
- R11: If a response arrives in the same cycle as a falling-SCL write in the receive state, the loaded byte is already advanced by one bit. The readback then shows its bit 6.
- R12: A write that repeats the previous line values changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe; lines are sampled when high |
| sda_in | input | 1 | Data line value written by software |
| scl_in | input | 1 | Clock line value written by software |
| sda_rd | output | 1 | Data line level returned on readback |
| start_stb | output | 1 | Open-transfer strobe |
| start_addr | output | BYTE_W-1 | Target address with the open strobe |
| start_rd | output | 1 | Read flag with the open strobe (1 = read) |
| send_stb | output | 1 | Send-byte strobe |
| send_data | output | BYTE_W | Byte with the send strobe |
| recv_req | output | 1 | Receive-byte request strobe |
| recv_valid | input | 1 | Response valid for a receive request |
| recv_data | input | BYTE_W | Response byte |
| end_stb | output | 1 | Close-transfer strobe |

## Verification
Two events can land in the same clock cycle: the target's response to a receive request, and a software write that drops SCL in the receive state. The bench disables its automatic target reply, issues the falling write for the master acknowledge, and then delivers the response byte in the very cycle of the next falling write. It judges the outcome on the readback line, which must show the byte's bit 6 rather than bit 7 and then bit 5 after one more falling edge. A stray response with no request outstanding is also injected mid-byte, and the readback must not move.

// File: rtl/i2c_gpio_framer.sv
module i2c_gpio_framer #(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_rd,
  output logic              start_stb,
  output logic [ADDR_W-1:0] start_addr,
  output logic              start_rd,
  output logic              send_stb,
  output logic [BYTE_W-1:0] send_data,
  output logic              recv_req,
  input  logic              recv_valid,
  input  logic [BYTE_W-1:0] recv_data,
  output logic              end_stb
);

  localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_TX, S_ACK, S_RX, S_MACK} st_t;

  st_t               st;
  logic [CNT_W-1:0]  bitn;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] addr_q;
  logic              addr_ok;
  logic              pend;
  logic              prev_sda, prev_scl;

  logic fall, is_start, is_stop, last_bit, take, go_read;

  assign fall     = wr_en & prev_scl & ~scl_in;
  assign is_start = wr_en & prev_sda & ~sda_in & scl_in;
  assign is_stop  = wr_en & ~prev_sda & sda_in & scl_in;
  assign last_bit = (bitn == '0);
  assign take     = recv_valid & pend;
  assign go_read  = addr_ok ? addr_q[0] : shreg[0];

  assign sda_rd = (st == S_RX)  ? shreg[BYTE_W-1] :
                  (st == S_ACK) ? 1'b0 : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bitn       <= TOP_BIT;
      shreg      <= '0;
      addr_q     <= '0;
      addr_ok    <= 1'b0;
      pend       <= 1'b0;
      prev_sda   <= 1'b1;
      prev_scl   <= 1'b1;
      start_stb  <= 1'b0;
      start_addr <= '0;
      start_rd   <= 1'b0;
      send_stb   <= 1'b0;
      send_data  <= '0;
      recv_req   <= 1'b0;
      end_stb    <= 1'b0;
    end else begin
      start_stb <= 1'b0;
      send_stb  <= 1'b0;
      recv_req  <= 1'b0;
      end_stb   <= 1'b0;

      if (wr_en) begin
        prev_sda <= sda_in;
        prev_scl <= scl_in;
      end

      if (take) begin
        pend  <= 1'b0;
        shreg <= (st == S_RX && fall) ? {recv_data[BYTE_W-2:0], 1'b1} : recv_data;
      end

      if (st != S_IDLE && is_stop) begin
        if (addr_ok) end_stb <= 1'b1;
        addr_ok <= 1'b0;
        pend    <= 1'b0;
        st      <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (is_start) st <= S_INIT;
          S_INIT: if (fall && !sda_in) begin
            st   <= S_TX;
            bitn <= TOP_BIT;
          end
          S_TX: if (fall) begin
            shreg <= {shreg[BYTE_W-2:0], sda_in};
            if (last_bit) st <= S_ACK;
            else bitn <= bitn - 1'b1;
          end
          S_ACK: if (fall) begin
            if (!addr_ok) begin
              addr_q     <= shreg;
              addr_ok    <= 1'b1;
              start_stb  <= 1'b1;
              start_addr <= shreg[BYTE_W-1:1];
              start_rd   <= shreg[0];
            end else begin
              send_stb  <= 1'b1;
              send_data <= shreg;
            end
            bitn <= TOP_BIT;
            if (go_read) begin
              st       <= S_RX;
              recv_req <= 1'b1;
              pend     <= 1'b1;
            end else begin
              st <= S_TX;
            end
          end
          S_RX: if (fall) begin
            if (!take) shreg <= {shreg[BYTE_W-2:0], 1'b1};
            if (last_bit) st <= S_MACK;
            else bitn <= bitn - 1'b1;
          end
          S_MACK: if (fall) begin
            st       <= S_RX;
            bitn     <= TOP_BIT;
            recv_req <= 1'b1;
            pend     <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> $past(wr_en && !scl_in));

  // R5
  send_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_stb |-> !addr_q[0]);

  // R6
  req_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recv_req |-> $past(wr_en && !scl_in));

  // R8
  end_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_stb |-> ($past(wr_en && sda_in && scl_in) && sda_rd));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb || send_stb || end_stb) |=> !(start_stb || send_stb || end_stb));

endmodule

// File: tb/test_i2c_gpio_framer.sv
module test_i2c_gpio_framer;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, sda_in = 1, scl_in = 1;
  logic sda_rd, start_stb, start_rd, send_stb, recv_req, end_stb;
  logic [6:0] start_addr;
  logic [7:0] send_data, recv_data;
  logic recv_valid;
  logic tgt_valid = 0, man_valid = 0, auto_on = 1;
  logic [7:0] man_data = 0;
  logic [1:0] tgt_cnt = 0;
  logic wr_seen = 0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [10:0] exp_q[$];

  always #2.5 clk = ~clk;

  assign recv_valid = tgt_valid | man_valid;
  assign recv_data  = man_valid ? man_data : 8'hA6;

  i2c_gpio_framer i_i2c_gpio_framer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sda_in(sda_in), .scl_in(scl_in),
    .sda_rd(sda_rd), .start_stb(start_stb), .start_addr(start_addr),
    .start_rd(start_rd), .send_stb(send_stb), .send_data(send_data),
    .recv_req(recv_req), .recv_valid(recv_valid), .recv_data(recv_data),
    .end_stb(end_stb));

  always @(posedge clk) begin
    wr_seen   <= wr_en;
    tgt_valid <= 1'b0;
    if (recv_req && auto_on) tgt_cnt <= 2'd1;
    else if (tgt_cnt == 2'd1) begin
      tgt_valid <= 1'b1;
      tgt_cnt   <= 2'd0;
    end
  end

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pop_cmp(input logic [1:0] kind, input logic [8:0] data);
    logic [10:0] e;
    if (exp_q.size() == 0) chk("R2 unexpected strobe", {kind, 7'h0}, 9'h1FF);
    else begin
      e = exp_q.pop_front();
      chk("R3/R5/R6/R8 strobe", {kind, data}, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (start_stb || send_stb || recv_req || end_stb)) begin
      chk("R9 strobe follows write", {8'h0, wr_seen}, 9'h1);
      if (start_stb) pop_cmp(2'd0, {start_addr, start_rd, 1'b0});
      if (recv_req)  pop_cmp(2'd2, 9'h0);
      if (send_stb)  pop_cmp(2'd1, {1'b0, send_data});
      if (end_stb)   pop_cmp(2'd3, 9'h0);
    end
  end

  task automatic push(input logic [1:0] kind, input logic [8:0] data);
    exp_q.push_back({kind, data});
  endtask

  task automatic wr(input logic d, input logic c);
    @(negedge clk);
    sda_in = d; scl_in = c; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reply(input logic d, input logic c, input logic [7:0] b);
    @(negedge clk);
    sda_in = d; scl_in = c; wr_en = 1; man_valid = 1; man_data = b;
    @(negedge clk);
    wr_en = 0; man_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_start();
    wr(0, 1);
    wr(0, 0);
  endtask

  task automatic do_stop();
    wr(0, 0);
    wr(0, 1);
    wr(1, 1);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wr(b[i], 0);
      wr(b[i], 1);
      if (i == 7) chk("R3 readback high while shifting", {8'h0, sda_rd}, 9'h1);
      wr(b[i], 0);
    end
    chk("R4 ack level after byte", {8'h0, sda_rd}, 9'h0);
    wr(1, 0);
    wr(1, 1);
    chk("R4 ack level with SCL high", {8'h0, sda_rd}, 9'h0);
    wr(1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 readback in reset", {8'h0, sda_rd}, 9'h1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 readback after reset", {8'h0, sda_rd}, 9'h1);
    chk("R1 no strobes", {5'h0, start_stb, send_stb, recv_req, end_stb}, 9'h0);

    // R2 / R12: clocking and repeated values while idle
    wr(1, 0); wr(1, 1); wr(1, 1); wr(1, 0); wr(1, 1);
    chk("R2 idle readback", {8'h0, sda_rd}, 9'h1);
    chk("R12 no queued output", 9'(exp_q.size()), 9'h0);

    // write transaction, address 0x50
    do_start();
    push(2'd0, {7'h50, 1'b0, 1'b0});
    send_byte(8'hA0);
    push(2'd1, 9'h03C);
    send_byte(8'h3C);
    push(2'd1, 9'h0C5);
    send_byte(8'hC5);
    push(2'd3, 9'h0);
    do_stop();
    chk("R8 idle after stop", {8'h0, sda_rd}, 9'h1);

    // R8: stop with no address held
    do_start();
    wr(0, 1);
    wr(1, 1);
    chk("R8 bare stop readback", {8'h0, sda_rd}, 9'h1);
    do_start();
    do_stop();
    chk("R8 no end strobe without address", 9'(exp_q.size()), 9'h0);

    // read transaction, address 0x2B
    do_start();
    push(2'd0, {7'h2B, 1'b1, 1'b0});
    push(2'd2, 9'h0);
    send_byte(8'h57);
    for (int i = 7; i >= 0; i--) begin
      if (i == 5) begin
        @(negedge clk); man_valid = 1; man_data = 8'h00;
        @(negedge clk); man_valid = 0;
        repeat (2) @(negedge clk);
        chk("R10 stray response ignored", {8'h0, sda_rd}, 9'h1);
      end
      chk("R6 read bit", {8'h0, sda_rd}, {8'h0, 8'hA6 >> i} & 9'h1);
      wr(1, 1);
      wr(1, 0);
    end
    chk("R7 master ack slot released", {8'h0, sda_rd}, 9'h1);
    auto_on = 0;
    wr(1, 1);
    push(2'd2, 9'h0);
    wr(1, 0);
    wr(1, 1);
    wr_reply(1, 0, 8'hB5);
    chk("R11 response with shift shows bit6", {8'h0, sda_rd}, 9'h0);
    wr(1, 1);
    wr(1, 0);
    chk("R11 next bit is bit5", {8'h0, sda_rd}, 9'h1);
    push(2'd3, 9'h0);
    do_stop();
    chk("R8 read stop readback", {8'h0, sda_rd}, 9'h1);

    repeat (5) @(negedge clk);
    chk("R9 all expected strobes seen", 9'(exp_q.size()), 9'h0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule